// File: doc/BRIEF.md
# Presettable Two-Section Ripple Counter

This block is a 4-bit counter made of two sections with separate clock inputs. The low section is one bit that toggles on each falling edge of its tick input. The high section is three bits that step on each falling edge of a second tick input. It divides by five or by eight, chosen by the `HI_MOD` parameter. Wiring output bit 0 to the high section's tick outside the block chains the two sections into a decade counter (`HI_MOD` = 5) or a divide-by-16 counter (`HI_MOD` = 8).

Two active-low controls sit on top of counting. `load_n` presets all four bits from `din`. While `load_n` stays low, the outputs keep following `din`, so the block also serves as a transparent 4-bit latch. `clear_n` forces all bits to zero and wins over both loading and counting.

The block runs on a fast system clock. The two tick inputs, `load_n` and `clear_n` each pass through a two-flop synchronizer. A falling edge is seen when the previous synchronized sample is 1 and the current one is 0.

Top module: `dual_ripple_counter`

## Requirements
- R1: After `rst_n` is released, `q` is 0000.
- R2: When `clear_n` goes low, `q` becomes 0000 on the third system clock edge after the change, even if `load_n` is low or a tick falls at the same time.
- R3: When `load_n` is low and `clear_n` is high, `q` takes the value of `din` on the third system clock edge after `load_n` falls. Falling tick edges during the load leave `q` equal to `din`.
- R4: While `load_n` stays low, a change on `din` appears on `q` one system clock later (transparent latch).
- R5: With `load_n` and `clear_n` high and no falling tick, `q` holds its value, and changes on `din` have no effect.
- R6: `q[0]` toggles once for each falling edge of `tick_lo`, three system clocks after that edge. A rising edge of `tick_lo` has no effect.
- R7: `q[3:1]`, with `q[1]` as its least significant bit, steps by one for each falling edge of `tick_hi`. `tick_lo` never changes `q[3:1]`, and `tick_hi` never changes `q[0]`.
- R8: With `HI_MOD` = 5, `q[3:1]` counts 0,1,2,3,4 and then returns to 0. If `q[3:1]` holds 5, 6 or 7, the next falling edge of `tick_hi` sets it to 0.
- R9: With `HI_MOD` = 8, `q[3:1]` counts 0 through 7 and then returns to 0.
- R10: With `HI_MOD` = 5 and `q[0]` wired to `tick_hi`, starting from 0, `q` equals n mod 10 after n falling edges of `tick_lo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all other inputs |
| rst_n | input | 1 | Active-low synchronous reset of the block state |
| tick_lo | input | 1 | Clock of the low (divide-by-two) section; acts on falling edges |
| tick_hi | input | 1 | Clock of the high section; acts on falling edges |
| load_n | input | 1 | Active-low preset / latch strobe |
| clear_n | input | 1 | Active-low clear to zero |
| din | input | 4 | Preset data; bit 0 feeds the low section |
| q | output | 4 | Counter state; bit 0 low section, bits 3:1 high section |

## Verification
Each control and tick passes through two synchronizer flops and then the state register. A change on `clear_n`, `load_n` or a tick therefore reaches `q` on the third rising clock edge. A `din` change while loading reaches `q` on the first edge. The bench drives inputs on falling clock edges and samples there too. For clear and load it checks that `q` is still old after the second edge and new after the third. The cascaded run waits long enough for the extra three-cycle hop from `q[0]` back through the high tick synchronizer.

// File: rtl/dual_ctr_pkg.sv
package dual_ctr_pkg;

    localparam int N_CTL   = 4;
    localparam int IDX_LO  = 0;
    localparam int IDX_HI  = 1;
    localparam int IDX_LD  = 2;
    localparam int IDX_CLR = 3;

    // Reset value of each synchronizer: ticks idle low, strobes idle high
    localparam logic [N_CTL-1:0] CTL_IDLE = 4'b1100;

    typedef struct packed {
        logic clear;
        logic load;
        logic step_lo;
        logic step_hi;
    } ctl_t;

endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic fell
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], async_in};
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_VAL}};
            st_q.prev <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.pipe[STAGES-1];
    assign fell  = st_q.prev & ~st_q.pipe[STAGES-1];

    // R6
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fell |=> !fell);

endmodule

// File: rtl/ctr_section.sv
module ctr_section #(
    parameter int W   = 3,
    parameter int MOD = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] LAST = W'(MOD - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } sec_st_t;

    sec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (step) begin
            st_d.cnt = (st_q.cnt >= LAST) ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign count = st_q.cnt;

    // R7
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load && st_q.cnt < LAST) |=> st_q.cnt == $past(st_q.cnt) + W'(1));

    // R8
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load && st_q.cnt >= LAST) |=> st_q.cnt == '0);

endmodule

// File: rtl/dual_ripple_counter.sv
module dual_ripple_counter
    import dual_ctr_pkg::*;
#(
    parameter int HI_MOD      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_lo,
    input  logic       tick_hi,
    input  logic       load_n,
    input  logic       clear_n,
    input  logic [3:0] din,
    output logic [3:0] q
);

    localparam int LO_MOD = 2;
    localparam int LO_W   = 1;
    localparam int HI_W   = $clog2(HI_MOD);
    localparam int DW     = LO_W + HI_W;

    logic [N_CTL-1:0] raw;
    logic [N_CTL-1:0] lvl;
    logic [N_CTL-1:0] fall;
    ctl_t             ctl;
    logic             unused_fall;

    assign raw = {clear_n, load_n, tick_hi, tick_lo};

    for (genvar g = 0; g < N_CTL; g++) begin : g_sync
        ctr_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(CTL_IDLE[g])
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(raw[g]),
            .level   (lvl[g]),
            .fell    (fall[g])
        );
    end

    assign unused_fall = ^fall[IDX_CLR:IDX_LD];

    always_comb begin
        ctl.clear   = ~lvl[IDX_CLR];
        ctl.load    = ~lvl[IDX_LD];
        ctl.step_lo = fall[IDX_LO];
        ctl.step_hi = fall[IDX_HI];
    end

    ctr_section #(.W(LO_W), .MOD(LO_MOD)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctl.clear),
        .load    (ctl.load),
        .step    (ctl.step_lo),
        .load_val(din[LO_W-1:0]),
        .count   (q[LO_W-1:0])
    );

    ctr_section #(.W(HI_W), .MOD(HI_MOD)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctl.clear),
        .load    (ctl.load),
        .step    (ctl.step_hi),
        .load_val(din[DW-1:LO_W]),
        .count   (q[DW-1:LO_W])
    );

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clear |=> q == '0);

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.clear && ctl.load) |=> q == $past(din));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.clear && !ctl.load && !ctl.step_lo && !ctl.step_hi) |=> $stable(q));

endmodule

// File: tb/dual_ripple_counter_tb_top.sv
`timescale 1ns/1ps
module dual_ripple_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_lo = 1'b0;
    logic       tick_hi_r = 1'b0;
    logic       casc = 1'b0;
    logic       load_n = 1'b1;
    logic       clear_n = 1'b1;
    logic [3:0] din = 4'h0;
    logic [3:0] q, q8;
    logic       tick_hi5;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    assign tick_hi5 = casc ? q[0] : tick_hi_r;

    dual_ripple_counter #(.HI_MOD(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi5),
        .load_n(load_n), .clear_n(clear_n), .din(din), .q(q));

    dual_ripple_counter #(.HI_MOD(8)) dut8_i (
        .clk(clk), .rst_n(rst_n), .tick_lo(tick_lo), .tick_hi(tick_hi_r),
        .load_n(load_n), .clear_n(clear_n), .din(din), .q(q8));

    // vector: [17:16] op, [15:12] data, [11:8] expected q, [7:0] requirement number
    localparam int NV = 17;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 4'h0, 4'h0, 8'd3},
        {2'd2, 4'h0, 4'h2, 8'd7},
        {2'd2, 4'h0, 4'h4, 8'd7},
        {2'd2, 4'h0, 4'h6, 8'd7},
        {2'd2, 4'h0, 4'h8, 8'd7},
        {2'd2, 4'h0, 4'h0, 8'd8},
        {2'd1, 4'h0, 4'h1, 8'd6},
        {2'd1, 4'h0, 4'h0, 8'd6},
        {2'd1, 4'h0, 4'h1, 8'd6},
        {2'd2, 4'h0, 4'h3, 8'd7},
        {2'd0, 4'hE, 4'hE, 8'd3},
        {2'd2, 4'h0, 4'h0, 8'd8},
        {2'd0, 4'hA, 4'hA, 8'd3},
        {2'd2, 4'h0, 4'h0, 8'd8},
        {2'd0, 4'h7, 4'h7, 8'd3},
        {2'd1, 4'h0, 4'h6, 8'd6},
        {2'd3, 4'h0, 4'h0, 8'd2}
    };

    function automatic string tag_of(input int n);
        case (n)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_lo();
        tick_lo = 1'b1; wait_n(4); tick_lo = 1'b0; wait_n(9);
    endtask

    task automatic pulse_hi();
        tick_hi_r = 1'b1; wait_n(4); tick_hi_r = 1'b0; wait_n(9);
    endtask

    task automatic do_load(input logic [3:0] d);
        din = d; load_n = 1'b0; wait_n(5); load_n = 1'b1; wait_n(5);
    endtask

    task automatic do_clear();
        clear_n = 1'b0; wait_n(5); clear_n = 1'b1; wait_n(5);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        check("R1", q, 4'h0);
        check("R1", q8, 4'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: do_load(VEC[i][15:12]);
                2'd1: pulse_lo();
                2'd2: pulse_hi();
                default: do_clear();
            endcase
            check(tag_of(int'(VEC[i][7:0])), q, VEC[i][11:8]);
        end

        // R3 latency: new value on the third edge after load_n falls
        din = 4'h5; load_n = 1'b0;
        wait_n(2); check("R3", q, 4'h0);
        wait_n(1); check("R3", q, 4'h5);
        // R4 transparent follow, one cycle
        din = 4'hA; wait_n(1); check("R4", q, 4'hA);
        din = 4'h3; wait_n(1); check("R4", q, 4'h3);
        // R3 load beats counting
        din = 4'h2; pulse_lo(); pulse_hi(); check("R3", q, 4'h2);
        load_n = 1'b1; wait_n(5);

        // R5 hold and din ignored
        din = 4'hF; wait_n(20); check("R5", q, 4'h2);

        // R6 rising edge does nothing, falling toggles
        tick_lo = 1'b1; wait_n(8); check("R6", q, 4'h2);
        tick_lo = 1'b0; wait_n(8); check("R6", q, 4'h3);

        // R2 latency and priority over load and counting
        din = 4'hF; load_n = 1'b0; clear_n = 1'b0; tick_lo = 1'b1;
        wait_n(2); check("R2", q, 4'h3);
        tick_lo = 1'b0;
        wait_n(1); check("R2", q, 4'h0);
        wait_n(6); check("R2", q, 4'h0);
        clear_n = 1'b1; load_n = 1'b1; wait_n(6);

        // R9 divide-by-eight section
        do_load(4'h0);
        for (int k = 1; k <= 8; k++) begin
            pulse_hi();
            check("R9", {1'b0, q8[3:1]}, 4'(k % 8));
        end

        // R10 cascaded decade
        do_load(4'h0);
        casc = 1'b1; wait_n(4);
        for (int k = 1; k <= 10; k++) begin
            pulse_lo();
            check("R10", q, 4'(k % 10));
        end
        casc = 1'b0;

        summary();
        $finish;
    end

endmodule